// File: doc/BRIEF.md
# Parcel-Chain Instruction Length Decoder

This block sits between an instruction fetch buffer and the decode stage of a processor whose instructions are built from 16-bit parcels. Each cycle it looks at a window of up to four parcels, taken in address order from the head of the buffer. It finds how many parcels form the instruction at the front and offers that instruction to the next stage, packed into a 64-bit word with the first parcel at the top.

The instruction length is not stored in a field. Every parcel has a continue flag in its least significant bit: a 1 means the next parcel belongs to the same instruction, and a 0 closes the instruction. Lengths of one, two, three or four parcels are allowed. The fourth parcel always closes the instruction. If that fourth parcel still has its continue flag set, the instruction is marked as malformed. When the window stops before the closing parcel, the block withholds its offer and reports that more parcels are needed.

The output uses a ready/valid handshake. In the same cycle as an accepted transfer, the block returns a consume count so the buffer can drop that many parcels at once. The decode path is purely combinational. A two-state offer tracker has these states:
- `ST_IDLE`: no offer is left pending.
- `ST_HOLD`: an offer was shown at the last edge and was not taken.

Its transitions are:
- Any state goes to `ST_HOLD` when valid is high and ready is low.
- Any state goes to `ST_IDLE` otherwise.
- Reset puts the tracker in `ST_IDLE`.

Top module: `vld_length_decoder`

## Requirements
- R1: The length in parcels is one plus the index of the first parcel, counted from 0, whose bit 0 is 0. `out_len` carries that length, from 1 to 4, whenever `out_valid` is high.
- R2: If parcels 0, 1 and 2 all have bit 0 set, the length is 4 whatever parcel 3 holds. `out_illegal` is 1 exactly when such a 4-parcel instruction is offered and parcel 3 also has bit 0 set. `out_illegal` is 0 at all other times.
- R3: When `win_count` is nonzero but smaller than the length needed, the outputs are as follows:
  - `out_valid` is 0 and `out_incomplete` is 1.
  - `out_len`, `out_insn` and `consume_cnt` are all 0.
  - With `win_count` = 0, both `out_valid` and `out_incomplete` are 0.
- R4: Parcel k of the instruction appears in `out_insn[63-16k : 48-16k]`, so parcel 0 sits in bits 63:48. The bits of parcels beyond the length are 0.
- R5: `consume_cnt` equals `out_len` in any cycle where `out_valid` and `out_ready` are both 1, and is 0 otherwise. There is no added cycle of latency.
- R6: Parcel k of the window is `win_parcels[16k+15 : 16k]`. Parcels at or beyond `win_count`, and parcels past the closing one, do not affect any output.
- R7: During reset, with an empty window, no instruction is offered and `consume_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the offer tracker |
| win_parcels | input | 64 | Four parcels from the buffer head; parcel k occupies bits 16k+15:16k |
| win_count | input | 3 | Number of valid parcels in the window, 0 to 4 |
| out_ready | input | 1 | Next stage accepts the offered instruction |
| out_valid | output | 1 | A complete instruction is offered |
| out_len | output | 3 | Instruction length in parcels (0 when not valid) |
| out_insn | output | 64 | Instruction, first parcel in the top 16 bits, unused parcels zero |
| out_illegal | output | 1 | Offered 4-parcel instruction has its last continue flag set |
| out_incomplete | output | 1 | Window ends before the instruction closes |
| consume_cnt | output | 3 | Parcels the buffer must drop this cycle |

## Verification
The assertions assume two things about the inputs. First, `win_count` never exceeds four. Second, the buffer keeps an unaccepted offer unchanged until it is taken, which is what the `ST_HOLD` check watches. The directed stimulus keeps every window count between zero and four. It changes inputs only on falling edges. In the one scenario that drops `out_ready` while an instruction is valid, the same window is presented again on the following cycle, this time with ready raised.

// File: rtl/vld_pkg.sv
package vld_pkg;
    localparam int unsigned PARCEL_W    = 16;
    localparam int unsigned MAX_PARCELS = 4;
    localparam int unsigned LEN_W       = $clog2(MAX_PARCELS + 1);
    localparam int unsigned WORD_W      = PARCEL_W * MAX_PARCELS;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } offer_state_e;
endpackage

// File: rtl/vld_chain_scan.sv
module vld_chain_scan #(
    parameter int unsigned MAX_PARCELS = vld_pkg::MAX_PARCELS,
    parameter int unsigned LEN_W       = vld_pkg::LEN_W
) (
    input  logic [MAX_PARCELS-1:0] cont_flags,
    input  logic [LEN_W-1:0]       avail,
    output logic [LEN_W-1:0]       chain_len,
    output logic                   complete,
    output logic                   bad_tail
);
    // Walk the continue flags; the last slot always closes the chain.
    always_comb begin
        logic found;
        found     = 1'b0;
        chain_len = '0;
        for (int i = 0; i < int'(MAX_PARCELS); i++) begin
            if (!found && (i == int'(MAX_PARCELS) - 1 || !cont_flags[i])) begin
                found     = 1'b1;
                chain_len = LEN_W'(i + 1);
            end
        end
    end

    assign complete = (avail >= chain_len);
    assign bad_tail = (chain_len == LEN_W'(MAX_PARCELS)) && cont_flags[MAX_PARCELS-1];
endmodule

// File: rtl/vld_assemble.sv
module vld_assemble #(
    parameter int unsigned PARCEL_W    = vld_pkg::PARCEL_W,
    parameter int unsigned MAX_PARCELS = vld_pkg::MAX_PARCELS,
    parameter int unsigned LEN_W       = vld_pkg::LEN_W,
    localparam int unsigned WORD_W     = PARCEL_W * MAX_PARCELS
) (
    input  logic [WORD_W-1:0] parcels,
    input  logic [LEN_W-1:0]  use_len,
    output logic [WORD_W-1:0] word
);
    // Slot k of the window lands k parcels below the top of the word.
    for (genvar k = 0; k < int'(MAX_PARCELS); k++) begin : g_slot
        assign word[WORD_W-1-k*PARCEL_W -: PARCEL_W] =
            (int'(use_len) > k) ? parcels[k*PARCEL_W +: PARCEL_W] : '0;
    end
endmodule

// File: rtl/vld_length_decoder.sv
module vld_length_decoder #(
    parameter int unsigned PARCEL_W    = vld_pkg::PARCEL_W,
    parameter int unsigned MAX_PARCELS = vld_pkg::MAX_PARCELS,
    localparam int unsigned LEN_W      = $clog2(MAX_PARCELS + 1),
    localparam int unsigned WORD_W     = PARCEL_W * MAX_PARCELS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] win_parcels,
    input  logic [LEN_W-1:0]  win_count,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [LEN_W-1:0]  out_len,
    output logic [WORD_W-1:0] out_insn,
    output logic              out_illegal,
    output logic              out_incomplete,
    output logic [LEN_W-1:0]  consume_cnt
);
    import vld_pkg::*;

    logic [MAX_PARCELS-1:0] cont_flags;
    logic [LEN_W-1:0]       chain_len;
    logic                   complete;
    logic                   bad_tail;
    offer_state_e           state_q, state_d;

    for (genvar k = 0; k < int'(MAX_PARCELS); k++) begin : g_flag
        assign cont_flags[k] = win_parcels[k*PARCEL_W];
    end

    vld_chain_scan #(.MAX_PARCELS(MAX_PARCELS), .LEN_W(LEN_W)) u_scan (
        .cont_flags (cont_flags),
        .avail      (win_count),
        .chain_len  (chain_len),
        .complete   (complete),
        .bad_tail   (bad_tail)
    );

    vld_assemble #(.PARCEL_W(PARCEL_W), .MAX_PARCELS(MAX_PARCELS), .LEN_W(LEN_W)) u_asm (
        .parcels (win_parcels),
        .use_len (out_len),
        .word    (out_insn)
    );

    // Offer tracker state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs.
    always_comb begin
        out_valid      = complete;
        out_incomplete = (win_count != '0) && !complete;
        out_len        = complete ? chain_len : '0;
        out_illegal    = complete && bad_tail;
        consume_cnt    = (complete && out_ready) ? chain_len : '0;
        unique case (state_q)
            ST_IDLE: state_d = (out_valid && !out_ready) ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = (out_valid && !out_ready) ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Assertions
    a_r1_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= LEN_W'(1)) && (out_len <= LEN_W'(MAX_PARCELS)));
    a_r2_illegal_full: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_valid && (out_len == LEN_W'(MAX_PARCELS)));
    a_r3_valid_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_incomplete));
    a_r3_fits_window: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len <= win_count));
    a_r4_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (out_len == LEN_W'(1)) |-> (out_insn[WORD_W-PARCEL_W-1:0] == '0));
    a_r5_consume_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_cnt != '0) |-> (out_valid && out_ready && consume_cnt == out_len));
    // R5: an offer left pending must be shown again unchanged (buffer obligation)
    a_r5_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> out_valid && $stable(out_insn));
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        win_count <= LEN_W'(MAX_PARCELS));
endmodule

// File: tb/vld_length_decoder_bench.sv
module vld_length_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] win_parcels = '0;
    logic [2:0]  win_count = '0;
    logic        out_ready = 1'b1;
    logic        out_valid, out_illegal, out_incomplete;
    logic [2:0]  out_len, consume_cnt;
    logic [63:0] out_insn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vld_length_decoder u_vld_length_decoder (
        .clk(clk), .rst_n(rst_n), .win_parcels(win_parcels), .win_count(win_count),
        .out_ready(out_ready), .out_valid(out_valid), .out_len(out_len),
        .out_insn(out_insn), .out_illegal(out_illegal),
        .out_incomplete(out_incomplete), .consume_cnt(consume_cnt)
    );

    task automatic apply(input logic [63:0] w, input logic [2:0] c, input logic r);
        @(negedge clk);
        win_parcels = w;
        win_count   = c;
        out_ready   = r;
        #5;
    endtask

    task automatic expect_out(input string tag, input logic v, input logic inc,
                              input logic ill, input logic [2:0] len,
                              input logic [63:0] insn, input logic [2:0] cons);
        checks++;
        if (out_valid !== v || out_incomplete !== inc || out_illegal !== ill ||
            out_len !== len || out_insn !== insn || consume_cnt !== cons) begin
            errors++;
            $display("FAIL %s: got v=%b inc=%b ill=%b len=%0d insn=%h cons=%0d exp v=%b inc=%b ill=%b len=%0d insn=%h cons=%0d",
                     tag, out_valid, out_incomplete, out_illegal, out_len, out_insn, consume_cnt,
                     v, inc, ill, len, insn, cons);
        end
    endtask

    task automatic t_reset();
        #5;
        expect_out("R7 reset idle", 0, 0, 0, 0, 64'h0, 0);
        repeat (3) @(posedge clk);
        #5;
        expect_out("R7 reset held", 0, 0, 0, 0, 64'h0, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_single();
        apply({16'h0, 16'h0, 16'h0, 16'h1234}, 3'd1, 1'b1);
        expect_out("R1 one parcel", 1, 0, 0, 1, 64'h1234_0000_0000_0000, 1);
        apply({16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h1234}, 3'd4, 1'b1);
        expect_out("R6 tail ignored", 1, 0, 0, 1, 64'h1234_0000_0000_0000, 1);
    endtask

    task automatic t_two();
        apply({16'h0, 16'h0, 16'h5A5A, 16'hA5A1}, 3'd2, 1'b1);
        expect_out("R1 two parcels", 1, 0, 0, 2, 64'hA5A1_5A5A_0000_0000, 2);
        apply({16'h7777, 16'h0, 16'h5A5A, 16'hA5A1}, 3'd3, 1'b1);
        expect_out("R4 zero tail", 1, 0, 0, 2, 64'hA5A1_5A5A_0000_0000, 2);
    endtask

    task automatic t_three();
        apply({16'hFFFF, 16'hBEEE, 16'h0003, 16'h0001}, 3'd3, 1'b1);
        expect_out("R1 three parcels", 1, 0, 0, 3, 64'h0001_0003_BEEE_0000, 3);
    endtask

    task automatic t_four();
        apply({16'hCAFE, 16'h1235, 16'h0003, 16'h0001}, 3'd4, 1'b1);
        expect_out("R2 four legal", 1, 0, 0, 4, 64'h0001_0003_1235_CAFE, 4);
        apply({16'hCAFF, 16'h1235, 16'h0003, 16'h0001}, 3'd4, 1'b1);
        expect_out("R2 four illegal", 1, 0, 1, 4, 64'h0001_0003_1235_CAFF, 4);
    endtask

    task automatic t_short();
        apply({16'h0, 16'h0, 16'h0, 16'h0001}, 3'd1, 1'b1);
        expect_out("R3 short 1", 0, 1, 0, 0, 64'h0, 0);
        apply({16'h0, 16'h0, 16'h0003, 16'h0001}, 3'd2, 1'b1);
        expect_out("R3 short 2", 0, 1, 0, 0, 64'h0, 0);
        apply({16'h0, 16'h0005, 16'h0003, 16'h0001}, 3'd3, 1'b1);
        expect_out("R3 short 3", 0, 1, 0, 0, 64'h0, 0);
        apply({16'h0, 16'h0005, 16'h0003, 16'h0001}, 3'd0, 1'b1);
        expect_out("R3 empty", 0, 0, 0, 0, 64'h0, 0);
    endtask

    task automatic t_stall();
        apply({16'h0, 16'h0, 16'h2222, 16'h1111}, 3'd2, 1'b0);
        expect_out("R5 ready low", 1, 0, 0, 2, 64'h1111_2222_0000_0000, 0);
        apply({16'h0, 16'h0, 16'h2222, 16'h1111}, 3'd2, 1'b1);
        expect_out("R5 accepted", 1, 0, 0, 2, 64'h1111_2222_0000_0000, 2);
    endtask

    initial begin
        t_reset();
        t_single();
        t_two();
        t_three();
        t_four();
        t_short();
        t_stall();
        apply(64'h0, 3'd0, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule